// File: doc/BRIEF.md
# Interlaced SD Raster Timing Generator

This block produces the raster timing for a standard-definition interlaced television output. It runs a pixel counter and a line counter that count one field at a time. From them it derives an active-video window, a vertical-sync pulse, a one-cycle line-compare event and a field flag that alternates from one field to the next. Downstream pixel fetch and encoding logic use these signals to know where they are in the raster.

Software programs the block through a simple write port. There are four word registers: a horizontal parameter word, a vertical parameter word, a miscellaneous word holding the line-compare value, and a control word. The totals are stored offset-encoded, the way a driver computes them. Reset loads defaults for either the 525-line or the 625-line standard, chosen by a standard-select input. A status word reports the live line count and the field identity. Software can therefore wait for a field start before it turns on interlaced output. A new parameter or interlace setting written while the raster runs is held back until the next field start.

Top module: `sd_raster_gen`

## Requirements
- R1: During reset, `std_sel`=0 loads defaults of 720 active and 858 total pixels per line (240 of 262 lines per field), and `std_sel`=1 loads 720 of 864 pixels (288 of 312 lines). Either default raster is 720 active cycles within each line of its length.
- R2: The register at address 0 holds (active pixels − 8) in [31:16] and (total pixels − 8) in [15:0]. The pixel counter counts 0 to total−1, then returns to 0 and advances the line counter.
- R3: The register at address 1 holds (active lines − 1) in [31:16] and (total lines − 1) in [15:0]. The line counter returns to 0 after line total−1, and the field flag inverts at that point, so one field lasts total pixels × total lines cycles.
- R4: `active` is high exactly when the pixel counter is below the active pixel count and the line counter is below the active line count.
- R5: `vsync` is high for exactly 3 whole lines, starting on the line whose number equals the active line count.
- R6: The register at address 2 holds a line-compare value in [27:16]. `line_cmp` pulses for exactly one cycle per field, at pixel 0 of the line equal to that value.
- R7: `status` carries the line counter in [11:0] and the field flag in bit 16, with all other bits zero.
- R8: The register at address 3 holds run enable in bit 0 and interlace enable in bit 1. While run enable is 0, both counters and the field flag are held at 0 and `active`, `vsync` and `line_cmp` stay low.
- R9: A write to address 0, 1 or 2 while the raster runs takes effect only from the next field start. While stopped, such a write takes effect at once.
- R10: `interlace_on` follows interlace enable only at a field start, or at once while stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| std_sel | input | 1 | Default standard: 0 = 525-line, 1 = 625-line (sampled in reset) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 horiz, 1 vert, 2 misc, 3 control) |
| wr_data | input | 32 | Register write data |
| pix_cnt | output | 12 | Current pixel counter |
| line_cnt | output | 12 | Current line-within-field counter |
| field | output | 1 | Field identity flag |
| active | output | 1 | Active-video window |
| vsync | output | 1 | Vertical-sync pulse |
| line_cmp | output | 1 | One-cycle line-compare event |
| interlace_on | output | 1 | Applied interlace enable |
| status | output | 32 | Line count [11:0], field flag [16] |

## Verification
On every cycle, the assertions check that the pixel counter never passes its decoded last value and that the field flag inverts at each field end. They also check that a stopped raster holds at zero, that the active window and sync never overlap, that sync always starts on the first line after active video, that the compare event lasts a single cycle, and that the applied settings stay frozen mid-field. The exact default line lengths, the number of active, sync and compare cycles in a whole field, and the status encoding are shown only by the bench scenarios. The same holds for the delay of a mid-field write until the next field start, which the bench measures as line lengths before and after that point.

// File: rtl/sdt_pkg.sv
// Shared types and reset defaults for the SD raster timing generator.
// Assumes 32-bit register words and the two supported standards.
package sdt_pkg;

    // Packed parameter word: upper half active count, lower half total count.
    typedef struct packed {
        logic [15:0] act;
        logic [15:0] tot;
    } sdt_par_t;

    typedef enum logic [1:0] {
        ADDR_HPAR = 2'd0,
        ADDR_VPAR = 2'd1,
        ADDR_MISC = 2'd2,
        ADDR_CTRL = 2'd3
    } sdt_addr_e;

    localparam int unsigned HACT_SD   = 720;
    localparam int unsigned HTOT_525  = 858;
    localparam int unsigned HTOT_625  = 864;
    localparam int unsigned VACT_525  = 240;
    localparam int unsigned VTOT_525  = 262;
    localparam int unsigned VACT_625  = 288;
    localparam int unsigned VTOT_625  = 312;

    // Horizontal default word in offset-8 encoding.
    function automatic sdt_par_t dflt_hpar(input logic std625);
        sdt_par_t p;
        p.act = 16'(HACT_SD - 8);
        p.tot = std625 ? 16'(HTOT_625 - 8) : 16'(HTOT_525 - 8);
        return p;
    endfunction

    // Vertical default word in offset-1 encoding.
    function automatic sdt_par_t dflt_vpar(input logic std625);
        sdt_par_t p;
        p.act = std625 ? 16'(VACT_625 - 1) : 16'(VACT_525 - 1);
        p.tot = std625 ? 16'(VTOT_625 - 1) : 16'(VTOT_525 - 1);
        return p;
    endfunction

    // Miscellaneous default: line compare one past the active line count.
    function automatic logic [31:0] dflt_misc(input logic std625);
        logic [11:0] cmp;
        cmp = std625 ? 12'(VACT_625 + 1) : 12'(VACT_525 + 1);
        return {4'b0, cmp, 16'b0};
    endfunction

endpackage

// File: rtl/sdt_regs.sv
// Register bank: software-written shadow copies plus applied copies that
// the counters use. Applied copies reload at a field end or while stopped.
// Assumes the field-end strobe comes from the counter block in this cycle.
module sdt_regs
    import sdt_pkg::*;
#(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             std_sel,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [31:0]      wr_data,
    input  logic             field_end,
    output logic             run_en,
    output sdt_par_t         hpar_app,
    output sdt_par_t         vpar_app,
    output logic [CNT_W-1:0] cmp_app,
    output logic             ilace_app
);
    sdt_par_t    hpar_sh, vpar_sh;
    logic [31:0] misc_sh;
    logic        ilace_sh;
    logic        apply;

    // Applied copies may change only at a field boundary or while stopped.
    assign apply = field_end || !run_en;

    // Shadow registers written by software; defaults per standard in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hpar_sh  <= dflt_hpar(std_sel);
            vpar_sh  <= dflt_vpar(std_sel);
            misc_sh  <= dflt_misc(std_sel);
            ilace_sh <= 1'b0;
            run_en   <= 1'b0;
        end else if (wr_en) begin
            case (sdt_addr_e'(wr_addr))
                ADDR_HPAR: hpar_sh <= sdt_par_t'(wr_data);
                ADDR_VPAR: vpar_sh <= sdt_par_t'(wr_data);
                ADDR_MISC: misc_sh <= wr_data;
                ADDR_CTRL: begin
                    run_en   <= wr_data[0];
                    ilace_sh <= wr_data[1];
                end
                default: ;
            endcase
        end
    end

    // Applied registers feeding counters and decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hpar_app  <= dflt_hpar(std_sel);
            vpar_app  <= dflt_vpar(std_sel);
            cmp_app   <= dflt_misc(std_sel)[16 +: CNT_W];
            ilace_app <= 1'b0;
        end else if (apply) begin
            hpar_app  <= hpar_sh;
            vpar_app  <= vpar_sh;
            cmp_app   <= misc_sh[16 +: CNT_W];
            ilace_app <= ilace_sh;
        end
    end

    // R9: mid-field, the applied parameters stay frozen.
    assert_frozen_mid_field_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !field_end) |=> ($stable(hpar_app) && $stable(vpar_app) && $stable(cmp_app)));

    // R10: interlace enable changes only at a field start or while stopped.
    assert_ilace_field_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !field_end) |=> $stable(ilace_app));

endmodule

// File: rtl/sdt_counters.sv
// Pixel, line and field counters. Counts one field at a time and flags
// the last cycle of a field. Assumes last values never change mid-field.
module sdt_counters #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] h_last,
    input  logic [CNT_W-1:0] v_last,
    output logic [CNT_W-1:0] h_cnt,
    output logic [CNT_W-1:0] v_cnt,
    output logic             field,
    output logic             field_end
);
    logic line_end;

    // End-of-line and end-of-field detection.
    assign line_end  = en && (h_cnt == h_last);
    assign field_end = line_end && (v_cnt == v_last);

    // Pixel counter: holds at 0 when stopped, wraps at the decoded total.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)  h_cnt <= '0;
        else if (line_end)  h_cnt <= '0;
        else                h_cnt <= h_cnt + 1'b1;
    end

    // Line counter: advances on each line end, wraps at the field end.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)  v_cnt <= '0;
        else if (field_end) v_cnt <= '0;
        else if (line_end)  v_cnt <= v_cnt + 1'b1;
    end

    // Field flag: inverts at each field end, cleared while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)  field <= 1'b0;
        else if (field_end) field <= ~field;
    end

    // R2: the pixel counter never goes past its last value.
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (h_cnt <= h_last));

    // R3: the field flag inverts at every field end.
    assert_field_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (field_end && en) |=> (field != $past(field)));

    // R8: stopping forces counters and field flag to zero.
    assert_hold_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (h_cnt == '0 && v_cnt == '0 && !field));

endmodule

// File: rtl/sdt_decode.sv
// Decodes the counters into active window, vertical sync and the
// line-compare event. Assumes active counts are already decoded.
module sdt_decode #(
    parameter int unsigned CNT_W    = 12,
    parameter int unsigned VS_LINES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] h_cnt,
    input  logic [CNT_W-1:0] v_cnt,
    input  logic [16:0]      h_act,
    input  logic [16:0]      v_act,
    input  logic [CNT_W-1:0] cmp,
    output logic             active,
    output logic             vsync,
    output logic             line_cmp
);
    localparam int unsigned PAD = 17 - CNT_W;

    logic [16:0] h_ext, v_ext;
    logic [17:0] vs_end;

    assign h_ext  = {{PAD{1'b0}}, h_cnt};
    assign v_ext  = {{PAD{1'b0}}, v_cnt};
    assign vs_end = {1'b0, v_act} + 18'(VS_LINES);

    // Window and event decode, all gated by the run enable.
    always_comb begin
        active   = en && (h_ext < h_act) && (v_ext < v_act);
        vsync    = en && (v_ext >= v_act) && ({1'b0, v_ext} < vs_end);
        line_cmp = en && (h_cnt == '0) && (v_cnt == cmp);
    end

    // R4: active video and sync never overlap.
    assert_active_no_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> !vsync);

    // R5: sync starts on the first line after active video.
    assert_sync_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vsync) |-> (v_ext == v_act && h_cnt == '0));

    // R6: the compare event lasts a single cycle.
    assert_cmp_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        line_cmp |=> !line_cmp);

endmodule

// File: rtl/sd_raster_gen.sv
// Top level of the SD interlaced raster timing generator. Connects the
// register bank, counters and decode, and packs the status word.
// Assumes CNT_W is at least 10 so the default totals fit.
module sd_raster_gen
    import sdt_pkg::*;
#(
    parameter int unsigned CNT_W    = 12,
    parameter int unsigned VS_LINES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             std_sel,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [31:0]      wr_data,
    output logic [CNT_W-1:0] pix_cnt,
    output logic [CNT_W-1:0] line_cnt,
    output logic             field,
    output logic             active,
    output logic             vsync,
    output logic             line_cmp,
    output logic             interlace_on,
    output logic [31:0]      status
);
    localparam int unsigned FIELD_BIT = 16;

    logic             run_en, field_end;
    sdt_par_t         hpar, vpar;
    logic [CNT_W-1:0] cmp_val, h_last, v_last;
    logic [16:0]      h_act, v_act;

    // Decode offset-encoded parameters into last values and active counts.
    always_comb begin
        h_last = CNT_W'(hpar.tot + 16'd7);
        v_last = CNT_W'(vpar.tot);
        h_act  = {1'b0, hpar.act} + 17'd8;
        v_act  = {1'b0, vpar.act} + 17'd1;
    end

    sdt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .std_sel   (std_sel),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .field_end (field_end),
        .run_en    (run_en),
        .hpar_app  (hpar),
        .vpar_app  (vpar),
        .cmp_app   (cmp_val),
        .ilace_app (interlace_on)
    );

    sdt_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (run_en),
        .h_last    (h_last),
        .v_last    (v_last),
        .h_cnt     (pix_cnt),
        .v_cnt     (line_cnt),
        .field     (field),
        .field_end (field_end)
    );

    sdt_decode #(.CNT_W(CNT_W), .VS_LINES(VS_LINES)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (run_en),
        .h_cnt    (pix_cnt),
        .v_cnt    (line_cnt),
        .h_act    (h_act),
        .v_act    (v_act),
        .cmp      (cmp_val),
        .active   (active),
        .vsync    (vsync),
        .line_cmp (line_cmp)
    );

    // Status word: line count in the low bits, field flag at bit 16.
    always_comb begin
        status            = 32'(line_cnt);
        status[FIELD_BIT] = field;
    end

endmodule

// File: tb/tb_sd_raster_gen.sv
// Directed bench for the SD raster timing generator.
module tb_sd_raster_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        std_sel = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [11:0] pix_cnt, line_cnt;
    logic        field, active, vsync, line_cmp, interlace_on;
    logic [31:0] status;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    sd_raster_gen dut (
        .clk(clk), .rst_n(rst_n), .std_sel(std_sel),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pix_cnt(pix_cnt), .line_cnt(line_cnt), .field(field),
        .active(active), .vsync(vsync), .line_cmp(line_cmp),
        .interlace_on(interlace_on), .status(status)
    );

    always #2.5 clk = ~clk;

    // Watchdog: an overlong run is a failed check, then the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog: actual %0d cycles, expected under 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic s);
        @(negedge clk);
        rst_n = 1'b0; std_sel = s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Wait (at negedges) for the first pixel of a line.
    task automatic wait_line_start();
        while (pix_cnt != 0) @(negedge clk);
    endtask

    // Wait for the first pixel of a field.
    task automatic wait_field_start();
        @(negedge clk);
        while (!(pix_cnt == 0 && line_cnt == 0)) @(negedge clk);
    endtask

    // Measure one line from its first pixel: length and active cycles.
    task automatic measure_line(output int len, output int act);
        len = 0; act = 0;
        do begin
            if (active) act++;
            len++;
            @(negedge clk);
        end while (pix_cnt != 0);
    endtask

    // R1: defaults of each standard after reset.
    task automatic t_defaults(input logic s, input int exp_len);
        int len, act;
        do_reset(s);
        @(negedge clk);
        check(pix_cnt == 0 && line_cnt == 0 && !field && !active && status == 0 && !interlace_on,
              "R1 reset state", int'(status), 0);
        wr(2'd3, 32'h1);
        @(negedge clk);
        wait_line_start();
        measure_line(len, act);
        check(len == exp_len, "R1 default line length", len, exp_len);
        check(act == 720, "R1 default active pixels", act, 720);
    endtask

    // Small raster: 12 of 20 pixels, 6 of 12 lines, compare at line 7.
    task automatic setup_small();
        do_reset(1'b0);
        wr(2'd0, {16'd4, 16'd12});
        wr(2'd1, {16'd5, 16'd11});
        wr(2'd2, {4'd0, 12'd7, 16'd0});
        wr(2'd3, 32'h1);
    endtask

    // R2..R6: one whole field of the small raster.
    task automatic t_field();
        int n_act = 0, n_vs = 0, n_cmp = 0, vs_first = -1, vs_last = -1;
        int cmp_line = -1, cmp_pix = -1, len, la;
        logic f0;
        setup_small();
        wait_field_start();
        f0 = field;
        for (int i = 0; i < 240; i++) begin
            if (active) n_act++;
            if (vsync) begin
                n_vs++;
                if (vs_first < 0) vs_first = int'(line_cnt);
                vs_last = int'(line_cnt);
            end
            if (line_cmp) begin
                n_cmp++; cmp_line = int'(line_cnt); cmp_pix = int'(pix_cnt);
            end
            @(negedge clk);
        end
        check(pix_cnt == 0 && line_cnt == 0, "R3 field length 240", int'(line_cnt), 0);
        check(field != f0, "R3 field flag toggled", int'(field), int'(!f0));
        check(n_act == 72, "R4 active cycles per field", n_act, 72);
        check(n_vs == 60, "R5 vsync cycles per field", n_vs, 60);
        check(vs_first == 6 && vs_last == 8, "R5 vsync first line", vs_first, 6);
        check(n_cmp == 1, "R6 compare pulses per field", n_cmp, 1);
        check(cmp_line == 7 && cmp_pix == 0, "R6 compare position", cmp_line, 7);
        measure_line(len, la);
        check(len == 20, "R2 line length 20", len, 20);
        check(la == 12, "R2 active pixels 12", la, 12);
    endtask

    // R7: status word encoding at line 3, field 1.
    task automatic t_status();
        setup_small();
        wait_field_start();
        while (!(field && pix_cnt == 0 && line_cnt == 0)) @(negedge clk);
        repeat (65) @(negedge clk);
        check(status == 32'h0001_0003, "R7 status word", int'(status), 32'h0001_0003);
    endtask

    // R8: stopping mid-field clears counters and flag.
    task automatic t_disable();
        setup_small();
        while (!(field && line_cnt == 2)) @(negedge clk);
        wr(2'd3, 32'h0);
        repeat (3) @(negedge clk);
        check(pix_cnt == 0 && line_cnt == 0 && !field, "R8 counters held", int'(line_cnt), 0);
        check(!active && !vsync && !line_cmp && status == 0, "R8 outputs low", int'(status), 0);
    endtask

    // R9 and R10: mid-field writes wait for the next field start.
    task automatic t_deferred();
        int len, la;
        setup_small();
        wait_field_start();
        repeat (30) @(negedge clk);
        wr(2'd0, {16'd4, 16'd8});
        wr(2'd3, 32'h3);
        @(negedge clk);
        wait_line_start();
        measure_line(len, la);
        check(len == 20, "R9 old line length before field start", len, 20);
        check(!interlace_on, "R10 interlace held mid-field", int'(interlace_on), 0);
        while (!(pix_cnt == 0 && line_cnt == 0)) @(negedge clk);
        check(interlace_on, "R10 interlace at field start", int'(interlace_on), 1);
        measure_line(len, la);
        check(len == 16, "R9 new line length after field start", len, 16);
    endtask

    initial begin
        t_defaults(1'b0, 858);
        t_defaults(1'b1, 864);
        t_field();
        t_status();
        t_disable();
        t_deferred();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule